// File: doc/BRIEF.md
# DS3 FEAC Message Transmit Controller

This block places a far-end alarm and control (FEAC) message on the serial C-bit channel of an outgoing DS3 frame. Software first loads a 6-bit FEAC code into a code register. It then enables the controller and writes a rising edge to the start bit of a byte-wide control and status register. The controller captures the code and sends a 16-bit framed codeword ten times back to back. It emits one bit on each pulse of a per-frame slot strobe that the frame generator supplies.

When the tenth copy has left the block, the busy flag drops and a sticky completion flag is raised. That flag drives an interrupt line if interrupts are enabled, and it clears when software reads the register. While no message is in progress, the serial output carries the all-ones idle pattern. Frame generation, the rest of the overhead and host address decoding stay outside the block: the register strobes and the slot strobe arrive as inputs.

Top module: `feac_tx_ctrl`

## Requirements
- R1: After reset every register bit is 0, the register reads 0x00, `feac_bit` is 1 and `irq` is 0. The register layout is: bit 4 interrupt enable, bit 3 completion status, bit 2 controller enable, bit 1 start, bit 0 busy. Bits 7 to 5 always read 0. Bits 4, 2 and 1 read back what was last written.
- R2: A transmission starts only on a write that takes the start bit from 0 to 1 while the enable bit of that same write is 1. A write that leaves the start bit at 1 starts nothing.
- R3: Each codeword is 16 bits, sent in this order: a 0, then the 6 code bits LSB first, then a 0, then eight 1s.
- R4: One start sends the codeword exactly 10 times back to back (160 bits). In the cycle after the 160th bit is shifted, busy reads 0 and the status bit reads 1.
- R5: Busy (bit 0) is read-only. It reads 1 from the cycle after the start write until the 160th bit is shifted, and writes to bit 0 have no effect.
- R6: `irq` is 1 exactly when both the status bit and the interrupt enable bit are 1.
- R7: A read returns the status bit as it was before the read and clears it. Writes to bit 3 have no effect. If a completion and a read fall in the same cycle, the status bit ends up 1.
- R8: While the enable bit is 0, `feac_bit` is 1 and starts are ignored. Clearing the enable bit during a message abandons it: busy drops and the status bit is not set.
- R9: `feac_bit` changes only on a cycle where `slot_stb` is 1. With no message in progress, a strobe shifts out a 1.
- R10: The code is captured at the start edge, so code writes during a message do not alter it. A start edge that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Write strobe for the control/status register |
| csr_rd | input | 1 | Read strobe for the control/status register (clears status) |
| csr_wdata | input | 8 | Write data for the control/status register |
| csr_rdata | output | 8 | Current control/status register contents |
| code_wr | input | 1 | Write strobe for the FEAC code register |
| code_wdata | input | CODE_W | FEAC code to load |
| slot_stb | input | 1 | One pulse per FEAC bit slot in the outgoing frame |
| feac_bit | output | 1 | Serial FEAC channel bit |
| irq | output | 1 | Completion interrupt |

## Verification
The bench targets five corner cases, each of which would show a distinct wrong output:
- Start bit held at 1: a level-triggered start would relaunch the message and hold busy high.
- Start edge written while the enable bit is 0: a design that latched it anyway would begin shifting code bits.
- Start edge and a new code written in the middle of a message: a design that restarted, or that read the code live, would emit a wrong bit or stay busy past bit 160.
- Read that lands in the same cycle as the final bit: a design where the clear beats the set would lose the event, and the status would read 0 afterwards.
- Enable cleared partway through a message: a design that kept shifting, or that flagged completion, would be caught by the idle-ones check and the status check that follow.

// File: rtl/feac_pkg.sv
package feac_pkg;

    // Control/status register bit positions (software-visible layout)
    localparam int CSR_BUSY = 0;
    localparam int CSR_GO   = 1;
    localparam int CSR_EN   = 2;
    localparam int CSR_IST  = 3;
    localparam int CSR_IE   = 4;
    localparam int CSR_W    = 8;
    localparam int CSR_USED = 5;

    typedef struct packed {
        logic ie;
        logic ist;
        logic en;
        logic go;
    } csr_ctl_t;

endpackage

// File: rtl/feac_codeword.sv
module feac_codeword #(
    parameter int CODE_W = 6,
    parameter int ONES_W = 8,
    localparam int LEN   = CODE_W + ONES_W + 2
) (
    input  logic [CODE_W-1:0] code,
    output logic [LEN-1:0]    word
);

    // Bit 0 is sent first: leading zero, code LSB first, zero, run of ones
    assign word[0]        = 1'b0;
    assign word[CODE_W+1] = 1'b0;

    for (genvar g = 0; g < CODE_W; g++) begin : g_code
        assign word[1+g] = code[g];
    end

    for (genvar h = 0; h < ONES_W; h++) begin : g_ones
        assign word[CODE_W+2+h] = 1'b1;
    end

endmodule

// File: rtl/feac_csr.sv
module feac_csr
    import feac_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CSR_W-1:0]  wdata,
    input  logic              code_wr,
    input  logic [CODE_W-1:0] code_wdata,
    input  logic              busy,
    input  logic              done,
    output logic [CSR_W-1:0]  rdata,
    output logic              start,
    output logic              run,
    output logic              irq,
    output logic [CODE_W-1:0] code
);

    localparam int PAD_W = CSR_W - CSR_USED;

    typedef struct packed {
        csr_ctl_t          ctl;
        logic [CODE_W-1:0] code;
    } csr_state_t;

    csr_state_t st_d, st_q;
    logic       wr_unused;

    // Bits that carry no writable state
    assign wr_unused = ^{wdata[CSR_W-1:CSR_USED], wdata[CSR_IST], wdata[CSR_BUSY]};

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (wr_en) begin
            st_d.ctl.ie = wdata[CSR_IE];
            st_d.ctl.en = wdata[CSR_EN];
            st_d.ctl.go = wdata[CSR_GO];
            start = wdata[CSR_GO] && !st_q.ctl.go && wdata[CSR_EN] && !busy;
        end
        if (code_wr) begin
            st_d.code = code_wdata;
        end
        if (rd_en) begin
            st_d.ctl.ist = 1'b0;
        end
        if (done) begin
            st_d.ctl.ist = 1'b1;   // set has priority over clear-on-read
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run   = st_d.ctl.en;
    assign code  = st_q.code;
    assign irq   = st_q.ctl.ist & st_q.ctl.ie;
    assign rdata = {{PAD_W{1'b0}}, st_q.ctl.ie, st_q.ctl.ist, st_q.ctl.en, st_q.ctl.go, busy};

endmodule

// File: rtl/feac_sequencer.sv
module feac_sequencer #(
    parameter int CODE_W  = 6,
    parameter int ONES_W  = 8,
    parameter int REPEATS = 10,
    localparam int LEN    = CODE_W + ONES_W + 2,
    localparam int IDX_W  = $clog2(LEN),
    localparam int REP_W  = (REPEATS > 1) ? $clog2(REPEATS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           start,
    input  logic           stb,
    input  logic [LEN-1:0] word_in,
    output logic           busy,
    output logic           done,
    output logic           bit_out
);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [REP_W-1:0] rep;
        logic [LEN-1:0]   word;
        logic             out;
    } seq_state_t;

    seq_state_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        done = 1'b0;
        if (!run) begin
            sq_d.busy = 1'b0;
            sq_d.idx  = '0;
            sq_d.rep  = '0;
            sq_d.out  = 1'b1;
        end else if (start) begin
            sq_d.busy = 1'b1;
            sq_d.idx  = '0;
            sq_d.rep  = '0;
            sq_d.word = word_in;
        end else if (stb) begin
            if (sq_q.busy) begin
                sq_d.out = sq_q.word[sq_q.idx];
                if (sq_q.idx == IDX_W'(LEN - 1)) begin
                    sq_d.idx = '0;
                    if (sq_q.rep == REP_W'(REPEATS - 1)) begin
                        sq_d.rep  = '0;
                        sq_d.busy = 1'b0;
                        done      = 1'b1;
                    end else begin
                        sq_d.rep = sq_q.rep + 1'b1;
                    end
                end else begin
                    sq_d.idx = sq_q.idx + 1'b1;
                end
            end else begin
                sq_d.out = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q      <= '0;
            sq_q.out  <= 1'b1;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy    = sq_q.busy;
    assign bit_out = sq_q.out;

endmodule

// File: rtl/feac_tx_ctrl.sv
module feac_tx_ctrl #(
    parameter int CODE_W  = 6,
    parameter int ONES_W  = 8,
    parameter int REPEATS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic              csr_rd,
    input  logic [7:0]        csr_wdata,
    output logic [7:0]        csr_rdata,
    input  logic              code_wr,
    input  logic [CODE_W-1:0] code_wdata,
    input  logic              slot_stb,
    output logic              feac_bit,
    output logic              irq
);

    localparam int LEN = CODE_W + ONES_W + 2;

    logic              start, run, busy, done;
    logic [CODE_W-1:0] code;
    logic [LEN-1:0]    word;

    feac_csr #(.CODE_W(CODE_W)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (csr_wr),
        .rd_en      (csr_rd),
        .wdata      (csr_wdata),
        .code_wr    (code_wr),
        .code_wdata (code_wdata),
        .busy       (busy),
        .done       (done),
        .rdata      (csr_rdata),
        .start      (start),
        .run        (run),
        .irq        (irq),
        .code       (code)
    );

    feac_codeword #(.CODE_W(CODE_W), .ONES_W(ONES_W)) u_word (
        .code (code),
        .word (word)
    );

    feac_sequencer #(.CODE_W(CODE_W), .ONES_W(ONES_W), .REPEATS(REPEATS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .start   (start),
        .stb     (slot_stb),
        .word_in (word),
        .busy    (busy),
        .done    (done),
        .bit_out (feac_bit)
    );

endmodule

// File: rtl/feac_tx_checker.sv
module feac_tx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] csr_rdata,
    input logic       slot_stb,
    input logic       feac_bit,
    input logic       irq
);

    // R1: upper bits never carry data
    a_r1_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[7:5] == 3'b000);

    // R6: interrupt line follows status and enable
    a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (csr_rdata[4] && csr_rdata[3]));

    // R5: busy only with the controller enabled
    a_r5_busy_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[0] |-> csr_rdata[2]);

    // R8: disabled controller drives idle ones
    a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rdata[2] |-> feac_bit);

    // R4: normal completion raises the status bit
    a_r4_done_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(csr_rdata[0]) && csr_rdata[2]) |-> csr_rdata[3]);

    // R9: output holds across cycles without a strobe
    a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_stb ##1 csr_rdata[2]) |-> $stable(feac_bit));

endmodule

bind feac_tx_ctrl feac_tx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_rdata (csr_rdata),
    .slot_stb  (slot_stb),
    .feac_bit  (feac_bit),
    .irq       (irq)
);

// File: tb/test_feac_tx_ctrl.sv
`timescale 1ns/1ps
module test_feac_tx_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csr_wr = 1'b0, csr_rd = 1'b0, code_wr = 1'b0, slot_stb = 1'b0;
    logic [7:0] csr_wdata = '0;
    logic [5:0] code_wdata = '0;
    logic [7:0] csr_rdata;
    logic       feac_bit, irq;
    int         n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    feac_tx_ctrl i_feac_tx_ctrl (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_rd(csr_rd),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .code_wr(code_wr),
        .code_wdata(code_wdata), .slot_stb(slot_stb), .feac_bit(feac_bit), .irq(irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Expected codeword bit k (R3): 0, code LSB first, 0, eight 1s
    function automatic logic exp_bit(input logic [5:0] c, input int k);
        if (k == 0 || k == 7) return 1'b0;
        if (k <= 6) return c[k-1];
        return 1'b1;
    endfunction

    task automatic wr_csr(input logic [7:0] v);
        @(negedge clk); csr_wr = 1'b1; csr_wdata = v;
        @(negedge clk); csr_wr = 1'b0;
    endtask

    task automatic wr_code(input logic [5:0] v);
        @(negedge clk); code_wr = 1'b1; code_wdata = v;
        @(negedge clk); code_wr = 1'b0;
    endtask

    task automatic rd_csr(output logic [7:0] v);
        @(negedge clk); csr_rd = 1'b1; #1 v = csr_rdata;
        @(negedge clk); csr_rd = 1'b0;
    endtask

    task automatic strobe(input string req, input logic exp, input bit gap);
        logic held;
        @(negedge clk); slot_stb = 1'b1;
        @(negedge clk); slot_stb = 1'b0;
        check(req, "feac_bit", feac_bit, exp);
        if (gap) begin
            held = feac_bit;
            @(negedge clk);
            check("R9", "hold between strobes", feac_bit, held);
        end
    endtask

    task automatic send_bits(input logic [5:0] c, input int from, input int upto);
        for (int k = from; k < upto; k++) strobe("R3", exp_bit(c, k % 16), (k % 7) == 3);
    endtask

    task automatic t_reset();
        check("R1", "reset rdata", csr_rdata, 8'h00);
        check("R1", "reset feac_bit", feac_bit, 1'b1);
        check("R1", "reset irq", irq, 1'b0);
        wr_csr(8'hE9);   // only pad, status and busy bits set: no effect
        check("R7", "status not writable", csr_rdata, 8'h00);
        check("R5", "busy not writable", csr_rdata[0], 1'b0);
        strobe("R9", 1'b1, 1'b0);
    endtask

    task automatic t_basic();
        logic [7:0] v;
        wr_code(6'h2D);
        wr_csr(8'h16);
        check("R2", "start edge", csr_rdata, 8'h17);
        send_bits(6'h2D, 0, 159);
        check("R5", "busy before last bit", csr_rdata[0], 1'b1);
        send_bits(6'h2D, 159, 160);
        check("R4", "done after 160 bits", csr_rdata, 8'h1E);
        check("R6", "irq on", irq, 1'b1);
        rd_csr(v);
        check("R7", "read sees status", v, 8'h1E);
        check("R7", "status cleared", csr_rdata, 8'h16);
        check("R6", "irq off", irq, 1'b0);
        strobe("R9", 1'b1, 1'b1);
    endtask

    task automatic t_held_go();
        wr_csr(8'h16);
        check("R2", "held start ignored", csr_rdata, 8'h16);
        strobe("R2", 1'b1, 1'b0);
    endtask

    task automatic t_disabled_start();
        wr_csr(8'h10);
        wr_csr(8'h12);
        check("R8", "start while disabled", csr_rdata, 8'h12);
        strobe("R8", 1'b1, 1'b0);
        strobe("R8", 1'b1, 1'b0);
    endtask

    task automatic t_latch_and_busy_start();
        logic [7:0] v;
        wr_csr(8'h04);
        wr_code(6'h13);
        wr_csr(8'h06);
        check("R2", "start", csr_rdata, 8'h07);
        send_bits(6'h13, 0, 50);
        wr_code(6'h3F);
        wr_csr(8'h04);
        wr_csr(8'h06);
        check("R10", "busy through restart attempt", csr_rdata, 8'h07);
        send_bits(6'h13, 50, 160);
        check("R10", "no restart after 160", csr_rdata, 8'h0E);
        check("R6", "irq masked", irq, 1'b0);
        rd_csr(v);
        check("R7", "read clears", csr_rdata, 8'h06);
    endtask

    task automatic t_read_set_collision();
        logic [7:0] v;
        wr_csr(8'h04);
        wr_code(6'h01);
        wr_csr(8'h06);
        send_bits(6'h01, 0, 159);
        @(negedge clk); slot_stb = 1'b1; csr_rd = 1'b1;
        #1 v = csr_rdata;
        @(negedge clk); slot_stb = 1'b0; csr_rd = 1'b0;
        check("R7", "read before set", v, 8'h07);
        check("R7", "set wins", csr_rdata, 8'h0E);
        check("R3", "last bit", feac_bit, 1'b1);
        rd_csr(v);
        check("R7", "second read", v, 8'h0E);
        check("R7", "cleared", csr_rdata, 8'h06);
    endtask

    task automatic t_abort();
        wr_csr(8'h04);
        wr_code(6'h2A);
        wr_csr(8'h06);
        send_bits(6'h2A, 0, 20);
        wr_csr(8'h00);
        check("R8", "abort clears busy", csr_rdata, 8'h00);
        check("R8", "abort idles", feac_bit, 1'b1);
        strobe("R8", 1'b1, 1'b0);
        wr_csr(8'h04);
        check("R8", "no status after abort", csr_rdata, 8'h04);
        strobe("R8", 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_held_go();
        t_disabled_start();
        t_latch_and_busy_start();
        t_read_set_collision();
        t_abort();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R4 watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule